// File: doc/BRIEF.md
# SDRAM Write-Burst Termination Sequencer

This block sits on the controller side of a single SDRAM bank. It turns host requests (open row, write, read, close) into encoded commands, column addresses, a data mask and a driven data bus. Its focus is how a write burst ends. A burst may run its programmed length. It may be cut off by a READ. It may be cut off by a PRECHARGE. For the PRECHARGE path, the sequencer holds the command back until write recovery has passed. It also masks the unwanted data words around that command and enforces the precharge period before the next row activation.

Write recovery (`t_wr_i`) and precharge period (`t_rp_i`) are cycle counts supplied as inputs. The burst length code and the auto-precharge choice are sampled with each WRITE request. The host offers one request per cycle. A request is taken when `ready_o` is high, and its command appears on the bus in the following cycle. Write data is taken from `wdata_i` one cycle before it appears on `dq_o`, so the host presents the first word with the WRITE request and each later word in the cycle after the previous one. While the sequencer waits for a timing window, it places NOP commands on the bus and holds `ready_o` low.

Top module: `sdram_wr_term_seq`

## Requirements
- R1: The command bus `{cs_n,ras_n,cas_n,we_n}` uses NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 and PRECHARGE=0010. After reset the bus shows NOP, DQM and the output enable are low, and `ready_o` is high.
- R2: Request op codes are ACTIVE=0, WRITE=1, READ=2 and PRECHARGE=3. When the bank is idle, an accepted ACTIVE appears on the next cycle with the requested row on `addr_o` and the requested bank on `ba_o`. A WRITE, READ or PRECHARGE requested while the bank is idle is dropped, and the bus stays NOP with the output enable low.
- R3: An accepted WRITE appears on the next cycle with its column on `addr_o` and the first data word on `dq_o` with the output enable high. `bl_i` codes 0 to 3 give bursts of 1, 2, 4 and 8 words. Each word is the `wdata_i` value from the previous cycle, and the output enable drops once the burst is complete.
- R4: A WRITE accepted during a running burst is issued on the next cycle with its own column and data word. The burst count restarts from the new request's length.
- R5: A READ accepted during a write burst is issued on the next cycle with `addr_o` bit 10 low. From that cycle the output enable stays low and no further word of the burst is driven.
- R6: An accepted PRECHARGE is placed on the earliest cycle that lies at least `t_wr_i` cycles after the last data cycle. NOPs fill the gap, and `ready_o` is low while waiting. With `t_wr_i`=1 and a word on the bus, PRECHARGE follows on the very next cycle.
- R7: When a PRECHARGE cuts a burst short, DQM is high on every cycle from the one after the last wanted word up to and including the PRECHARGE cycle. When the burst had already completed, DQM stays low.
- R8: After a PRECHARGE on cycle p, `ready_o` stays low until an ACTIVE can be placed on cycle p+`t_rp_i`. An ACTIVE accepted at the first ready cycle lands exactly there.
- R9: A WRITE with `auto_pre_i` high and a fixed length is issued with `addr_o` bit 10 high. No PRECHARGE command follows, `ready_o` stays low through the burst and recovery, and the earliest ACTIVE falls `t_wr_i`+`t_rp_i` cycles after the last data cycle. For a full-page burst, `auto_pre_i` is ignored and bit 10 stays low.
- R10: `bl_i` codes 4 to 7 select a full-page burst. Such a burst drives a new word every cycle without end until a PRECHARGE or READ cuts it off.
- R11: An ACTIVE requested while a row is open is dropped: the bus stays NOP and `ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t_wr_i | input | TW | Write recovery in cycles |
| t_rp_i | input | TW | Precharge period in cycles |
| bl_i | input | BL_CODE_W+1 | Burst length code, sampled with WRITE |
| auto_pre_i | input | 1 | Auto precharge for this WRITE |
| req_valid_i | input | 1 | Host request valid |
| req_op_i | input | 2 | Host request op |
| req_bank_i | input | BA_W | Bank for ACTIVE |
| req_addr_i | input | ADDR_W | Row for ACTIVE, column for WRITE/READ |
| wdata_i | input | DQ_W | Write data stream |
| ready_o | output | 1 | Request can be accepted |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/column address |
| dqm_o | output | 1 | Data mask |
| dq_oe_o | output | 1 | Data output enable |
| dq_o | output | DQ_W | Write data |

## Verification
A wrong beat count shows up directly at the pins. The output enable stays high, or drops, one cycle away from the programmed length, and this is visible on the first burst of that length. A stale write-recovery gap or precharge counter moves the PRECHARGE command, or the first cycle with `ready_o` high, by whole cycles. The directed cases therefore sample those pins on the exact cycle each count predicts. A lost truncation flag inverts DQM on the cycle before the PRECHARGE and on the PRECHARGE cycle itself, so both cycles are checked for every cut and every completed burst.

// File: rtl/sdram_wt_pkg.sv
`timescale 1ns/1ps
package sdram_wt_pkg;
  localparam logic [1:0] OP_ACT = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_PRE = 2'd3;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_WR, ST_PRE_WAIT, ST_AP
  } seq_state_e;
endpackage

// File: rtl/wt_down_ctr.sv
`timescale 1ns/1ps
module wt_down_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (load_i)                  cnt_o <= val_i;
    else if (dec_i && cnt_o != '0)    cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wt_gap_ctr.sv
`timescale 1ns/1ps
module wt_gap_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] gap_o
);
  // cycles since the last data cycle, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_o <= '1;
    else if (clr_i)       gap_o <= '0;
    else if (~&gap_o)     gap_o <= gap_o + 1'b1;
  end
endmodule

// File: rtl/sdram_wr_term_seq.sv
`timescale 1ns/1ps
module sdram_wr_term_seq
  import sdram_wt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int DQ_W      = 16,
  parameter int TW        = 4,
  parameter int BL_CODE_W = 2,
  parameter int AP_BIT    = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TW-1:0]        t_wr_i,
  input  logic [TW-1:0]        t_rp_i,
  input  logic [BL_CODE_W:0]   bl_i,
  input  logic                 auto_pre_i,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [BA_W-1:0]      req_bank_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DQ_W-1:0]      wdata_i,
  output logic                 ready_o,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 dqm_o,
  output logic                 dq_oe_o,
  output logic [DQ_W-1:0]      dq_o
);
  localparam int BEAT_W = (1 << BL_CODE_W) - 1;

  seq_state_e        state_q, state_d;
  logic [BA_W-1:0]   bank_q, bank_d;
  logic              full_q, full_d, cut_q, cut_d;
  logic [3:0]        cmd_q, nxt_cmd;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic              dqm_q, nxt_dqm, oe_q, nxt_oe;
  logic [DQ_W-1:0]   dq_q, nxt_dq;

  logic [BEAT_W-1:0] left_q, len_m1;
  logic              beat_load, beat_dec;
  logic [TW-1:0]     gap_q, gap_next, rp_q;
  logic              rp_load, wr_ok, burst_more, accept;
  logic              start_wr, do_rd, do_pre, cont;

  wt_down_ctr #(.W(BEAT_W)) u_beat (
    .clk_i, .rst_ni, .load_i(beat_load), .val_i(len_m1), .dec_i(beat_dec), .cnt_o(left_q)
  );
  wt_down_ctr #(.W(TW)) u_rp (
    .clk_i, .rst_ni, .load_i(rp_load), .val_i(t_rp_i), .dec_i(1'b1), .cnt_o(rp_q)
  );
  wt_gap_ctr #(.W(TW)) u_gap (
    .clk_i, .rst_ni, .clr_i(nxt_oe), .gap_o(gap_q)
  );

  assign len_m1     = BEAT_W'((1 << bl_i[BL_CODE_W-1:0]) - 1);
  assign gap_next   = (&gap_q) ? gap_q : gap_q + 1'b1;
  assign wr_ok      = gap_next >= t_wr_i;
  assign burst_more = full_q || (left_q != '0);

  always_comb begin
    case (state_q)
      ST_IDLE:       ready_o = (rp_q <= TW'(1));
      ST_OPEN, ST_WR: ready_o = 1'b1;
      default:       ready_o = 1'b0;
    endcase
  end
  assign accept = req_valid_i && ready_o;

  always_comb begin
    state_d   = state_q;
    bank_d    = bank_q;
    full_d    = full_q;
    cut_d     = cut_q;
    nxt_cmd   = CMD_NOP;
    nxt_addr  = '0;
    nxt_dqm   = 1'b0;
    nxt_oe    = 1'b0;
    nxt_dq    = '0;
    beat_load = 1'b0;
    beat_dec  = 1'b0;
    rp_load   = 1'b0;
    start_wr  = 1'b0;
    do_rd     = 1'b0;
    do_pre    = 1'b0;
    cont      = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (accept && req_op_i == OP_ACT) begin
          nxt_cmd  = CMD_ACT;
          nxt_addr = req_addr_i;
          bank_d   = req_bank_i;
          state_d  = ST_OPEN;
        end
      end
      ST_OPEN, ST_WR: begin
        start_wr = accept && req_op_i == OP_WR;
        do_rd    = accept && req_op_i == OP_RD;
        do_pre   = accept && req_op_i == OP_PRE;
        if (state_q == ST_WR && !start_wr && !do_rd && !do_pre) begin
          if (burst_more) cont = 1'b1;
          else            state_d = ST_OPEN;
        end
      end
      ST_PRE_WAIT: begin
        nxt_dqm = cut_q;
        if (wr_ok) begin
          nxt_cmd = CMD_PRE;
          rp_load = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_AP: begin
        if (burst_more) cont = 1'b1;
        else if (wr_ok) begin
          rp_load = 1'b1;  // internal precharge starts here
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (cont) begin
      nxt_oe   = 1'b1;
      nxt_dq   = wdata_i;
      beat_dec = 1'b1;
    end

    if (start_wr) begin
      nxt_cmd          = CMD_WR;
      nxt_addr         = req_addr_i;
      nxt_addr[AP_BIT] = auto_pre_i && !bl_i[BL_CODE_W];
      nxt_oe           = 1'b1;
      nxt_dq           = wdata_i;
      beat_load        = 1'b1;
      full_d           = bl_i[BL_CODE_W];
      state_d          = (auto_pre_i && !bl_i[BL_CODE_W]) ? ST_AP : ST_WR;
    end

    if (do_rd) begin
      nxt_cmd          = CMD_RD;
      nxt_addr         = req_addr_i;
      nxt_addr[AP_BIT] = 1'b0;
      state_d          = ST_OPEN;
    end

    if (do_pre) begin
      cut_d   = (state_q == ST_WR) && burst_more;
      nxt_dqm = cut_d;
      if (wr_ok) begin
        nxt_cmd = CMD_PRE;
        rp_load = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = ST_PRE_WAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      full_q  <= 1'b0;
      cut_q   <= 1'b0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      dqm_q   <= 1'b0;
      oe_q    <= 1'b0;
      dq_q    <= '0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      full_q  <= full_d;
      cut_q   <= cut_d;
      cmd_q   <= nxt_cmd;
      addr_q  <= nxt_addr;
      dqm_q   <= nxt_dqm;
      oe_q    <= nxt_oe;
      dq_q    <= nxt_dq;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign ba_o    = bank_q;
  assign addr_o  = addr_q;
  assign dqm_o   = dqm_q;
  assign dq_oe_o = oe_q;
  assign dq_o    = dq_q;
endmodule

// File: rtl/wt_term_chk.sv
`timescale 1ns/1ps
module wt_term_chk
  import sdram_wt_pkg::*;
#(
  parameter int TW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_n_o,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic          dqm_o,
  input logic          dq_oe_o,
  input logic [TW-1:0] t_wr_i,
  input logic [TW-1:0] t_rp_i
);
  logic [3:0] cmd;
  logic [7:0] since_data, since_pre;
  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_data <= '1;
      since_pre  <= '1;
    end else begin
      since_data <= dq_oe_o ? 8'd1 : ((&since_data) ? since_data : since_data + 8'd1);
      since_pre  <= (cmd == CMD_PRE) ? 8'd1 : ((&since_pre) ? since_pre : since_pre + 8'd1);
    end
  end

  a_r5_rd_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD) |-> !dq_oe_o);

  a_r6_pre_after_twr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> (since_data >= 8'(t_wr_i)));

  a_r8_act_after_trp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> (since_pre >= 8'(t_rp_i)));

  a_r7_mask_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE && dqm_o && t_wr_i >= TW'(2)) |-> $past(dqm_o));

  a_r7_no_mask_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dqm_o && dq_oe_o));

  a_r3_oe_only_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (cmd == CMD_WR || cmd == CMD_NOP));
endmodule

bind sdram_wr_term_seq wt_term_chk #(.TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .dqm_o(dqm_o), .dq_oe_o(dq_oe_o), .t_wr_i(t_wr_i), .t_rp_i(t_rp_i)
);

// File: tb/sim_sdram_wr_term_seq.sv
`timescale 1ns/1ps
module sim_sdram_wr_term_seq;
  import sdram_wt_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  t_wr_i = 4'd2, t_rp_i = 4'd3;
  logic [2:0]  bl_i = 3'd2;
  logic        auto_pre_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [1:0]  req_bank_i = 2'd0;
  logic [11:0] req_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ready_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dqm_o, dq_oe_o;
  logic [1:0]  ba_o;
  logic [11:0] addr_o;
  logic [15:0] dq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  sdram_wr_term_seq u0 (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic tick(); @(posedge clk_i); #1; endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] bus();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic send(logic [1:0] op, logic [11:0] a);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a;
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic open_row(logic [11:0] row);
    for (int k = 0; k < 64 && !ready_o; k++) tick();
    req_bank_i = 2'd1;
    send(OP_ACT, row);
    check("R2 open row cmd", bus(), CMD_ACT);
  endtask

  task automatic t_reset_idle();
    check("R1 reset cmd", bus(), CMD_NOP);
    check("R1 reset oe", dq_oe_o, 0);
    check("R1 reset dqm", dqm_o, 0);
    check("R1 reset ready", ready_o, 1);
    wdata_i = 16'hdead;
    send(OP_WR, 12'h011);
    check("R2 write while idle dropped", bus(), CMD_NOP);
    check("R2 no data while idle", dq_oe_o, 0);
    req_bank_i = 2'd1;
    send(OP_ACT, 12'h123);
    check("R2 act cmd", bus(), CMD_ACT);
    check("R2 act row", addr_o, 12'h123);
    check("R2 act bank", ba_o, 2'd1);
    req_bank_i = 2'd2;
    send(OP_ACT, 12'h321);
    check("R11 act on open row dropped", bus(), CMD_NOP);
    check("R11 ready stays", ready_o, 1);
  endtask

  task automatic t_bl4();
    t_wr_i = 4'd2; bl_i = 3'd2; auto_pre_i = 1'b0;
    wdata_i = 16'h1000;
    send(OP_WR, 12'h010);
    check("R3 wr cmd", bus(), CMD_WR);
    check("R3 wr col", addr_o, 12'h010);
    check("R3 first word", dq_o, 16'h1000);
    check("R3 first oe", dq_oe_o, 1);
    for (int i = 1; i < 4; i++) begin
      wdata_i = 16'h1000 + 16'(i);
      tick();
      check("R3 burst word", dq_o, 16'h1000 + 16'(i));
      check("R3 burst oe", dq_oe_o, 1);
    end
    tick();
    check("R3 oe drops after 4", dq_oe_o, 0);
  endtask

  task automatic t_pre_cut();
    t_wr_i = 4'd3; t_rp_i = 4'd3; bl_i = 3'd3;
    wdata_i = 16'h2000;
    send(OP_WR, 12'h020);
    wdata_i = 16'h2001;
    tick();
    check("R3 word 2", dq_o, 16'h2001);
    send(OP_PRE, 12'h000);
    check("R6 wait nop", bus(), CMD_NOP);
    check("R7 mask 1", dqm_o, 1);
    check("R6 oe off", dq_oe_o, 0);
    check("R6 busy", ready_o, 0);
    tick();
    check("R6 wait nop 2", bus(), CMD_NOP);
    check("R7 mask before pre", dqm_o, 1);
    tick();
    check("R6 pre at t_wr", bus(), CMD_PRE);
    check("R7 mask on pre", dqm_o, 1);
    check("R8 busy at pre", ready_o, 0);
    tick();
    check("R8 busy p+1", ready_o, 0);
    tick();
    check("R8 ready p+2", ready_o, 1);
    send(OP_ACT, 12'h055);
    check("R8 act at p+trp", bus(), CMD_ACT);
  endtask

  task automatic t_pre_complete();
    t_wr_i = 4'd2; bl_i = 3'd1;
    wdata_i = 16'h3000;
    send(OP_WR, 12'h030);
    wdata_i = 16'h3001;
    tick();
    send(OP_PRE, 12'h000);
    check("R7 no mask after full burst", dqm_o, 0);
    check("R6 nop gap", bus(), CMD_NOP);
    tick();
    check("R6 pre complete", bus(), CMD_PRE);
    check("R7 no mask on pre", dqm_o, 0);
    open_row(12'h066);
    t_wr_i = 4'd1; bl_i = 3'd2;
    wdata_i = 16'h4000;
    send(OP_WR, 12'h040);
    send(OP_PRE, 12'h000);
    check("R6 twr1 pre next", bus(), CMD_PRE);
    check("R7 twr1 mask", dqm_o, 1);
    check("R6 twr1 oe", dq_oe_o, 0);
    open_row(12'h077);
  endtask

  task automatic t_read_cut();
    bl_i = 3'd3;
    wdata_i = 16'h5000;
    send(OP_WR, 12'h050);
    wdata_i = 16'h5001; tick();
    wdata_i = 16'h5002; tick();
    check("R3 word 3", dq_o, 16'h5002);
    send(OP_RD, 12'h404);
    check("R5 rd cmd", bus(), CMD_RD);
    check("R5 rd addr", addr_o, 12'h004);
    check("R5 rd oe", dq_oe_o, 0);
    tick();
    check("R5 no more data", dq_oe_o, 0);
    check("R5 ready", ready_o, 1);
  endtask

  task automatic t_b2b();
    bl_i = 3'd1;
    wdata_i = 16'h6000; send(OP_WR, 12'h031);
    check("R4 wr a", dq_o, 16'h6000);
    wdata_i = 16'h6001; send(OP_WR, 12'h032);
    check("R4 wr b cmd", bus(), CMD_WR);
    check("R4 wr b col", addr_o, 12'h032);
    check("R4 wr b data", dq_o, 16'h6001);
    wdata_i = 16'h6002; send(OP_WR, 12'h033);
    check("R4 wr c data", dq_o, 16'h6002);
    wdata_i = 16'h6003; tick();
    check("R4 restarted tail", dq_o, 16'h6003);
    check("R4 tail oe", dq_oe_o, 1);
    tick();
    check("R4 ends after 2", dq_oe_o, 0);
  endtask

  task automatic t_full_page();
    auto_pre_i = 1'b1; bl_i = 3'd4; t_wr_i = 4'd2;
    wdata_i = 16'h7000;
    send(OP_WR, 12'h050);
    check("R9 full page a10 low", addr_o[10], 0);
    for (int i = 1; i < 12; i++) begin
      wdata_i = 16'h7000 + 16'(i);
      tick();
      check("R10 full page word", dq_o, 16'h7000 + 16'(i));
    end
    auto_pre_i = 1'b0;
    send(OP_PRE, 12'h000);
    check("R10 cut mask", dqm_o, 1);
    tick();
    check("R10 pre ends page", bus(), CMD_PRE);
    open_row(12'h088);
  endtask

  task automatic t_auto_pre();
    auto_pre_i = 1'b1; bl_i = 3'd1; t_wr_i = 4'd2; t_rp_i = 4'd3;
    wdata_i = 16'h8000;
    send(OP_WR, 12'h060);
    auto_pre_i = 1'b0;
    check("R9 a10 high", addr_o, 12'h460);
    check("R9 busy", ready_o, 0);
    wdata_i = 16'h8001; tick();
    check("R9 second word", dq_o, 16'h8001);
    tick();
    check("R9 busy L+1", ready_o, 0);
    tick();
    check("R9 no pre cmd", bus(), CMD_NOP);
    check("R9 busy L+2", ready_o, 0);
    tick();
    check("R9 busy L+3", ready_o, 0);
    tick();
    check("R9 ready L+4", ready_o, 1);
    send(OP_ACT, 12'h099);
    check("R9 act at L+twr+trp", bus(), CMD_ACT);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    t_reset_idle();
    t_bl4();
    t_pre_cut();
    t_pre_complete();
    t_read_cut();
    t_b2b();
    t_full_page();
    t_auto_pre();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule